// File: doc/BRIEF.md
# Maskable Interrupt Aggregator with Acknowledge Readout

This block collects interrupt events from two sources into an 8-bit pending register. A free-running timer raises a tick once every second. A peripheral poll result can arrive with a reply of up to `REPLY_BYTES` bytes. An 8-bit mask selects which pending bits drive the active-low interrupt output `irqN`. A command engine sits next to the block and serves two operations on it: acknowledge and set-mask. Each command comes with an argument count and a first argument byte. The answer goes back as a packed response buffer with a byte count.

The acknowledge readout depends on what is pending.
- If a peripheral reply is waiting, acknowledge returns a status byte followed by the stored reply bytes. It then clears only the two peripheral bits.
- In every other case, acknowledge returns the whole pending register as one byte and clears all of it.

Events win over a clear that happens in the same cycle, so no tick or poll result is lost.

Top module: `irq_gather`

## Requirements
- R1: `irqN` is 0 when (pending AND mask) is nonzero and 1 otherwise. It follows every change of either register, one clock after the command or event that caused it.
- R2: After reset the pending register is 0x00, the mask is 0x30 (tick bit and peripheral bit enabled), and `irqN` is 1.
- R3: Pending bit positions are: tick = bit 5, peripheral reply = bit 4, auto-poll = bit 2.
  - A poll result (`pollValid` high) is taken only if bit 4 is clear and `pollLen` is nonzero.
  - A taken result sets bits 4 and 2 and stores `pollLen` (clamped to `REPLY_BYTES`) together with the bytes `pollData[8*i+:8]`.
  - A result that is not taken has no effect.
- R4: Acknowledge is `cmdOp`=0 with `cmdArgCount`=0. When bit 4 is pending, it answers `rspLen` = stored length + 1.
  - Byte 0 is pending AND 0x14, followed by the stored bytes in order.
  - Only bits 4 and 2 and the stored length are cleared.
- R5: An acknowledge with bit 4 not pending answers one byte equal to the whole pending register, then clears every pending bit.
- R6: An acknowledge with a nonzero argument count answers with `rspLen`=0 and changes neither register.
- R7: Set-mask is `cmdOp`=1. With `cmdArgCount`=1 it loads `cmdArg0` into the mask. With any other count it is ignored. It always answers with `rspLen`=0.
- R8: Bit 5 is set every `TICK_MS`*`CLK_PER_MS` cycles regardless of the mask. Each deadline is the previous one plus that period, so the period does not drift, however long acknowledges take.
- R9: A tick or a taken poll result in the same cycle as an acknowledge clear stays pending.
- R10: `rspValid` pulses one cycle after each `cmdValid`. Response byte i appears at `rspData[8*i+:8]`, and unused bytes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle |
| cmdOp | input | 1 | 0 = acknowledge, 1 = set mask |
| cmdArgCount | input | 8 | Number of argument bytes supplied |
| cmdArg0 | input | 8 | First argument byte |
| pollValid | input | 1 | Poll result strobe, one cycle |
| pollLen | input | LEN_W | Reply length in bytes |
| pollData | input | 8*REPLY_BYTES | Reply bytes, byte i at bits 8*i+7:8*i |
| rspValid | output | 1 | Response strobe |
| rspLen | output | RSP_W | Response byte count |
| rspData | output | 8*(REPLY_BYTES+1) | Response bytes |
| irqN | output | 1 | Active-low interrupt |

## Verification
Acknowledge is exercised in each of its readout regimes:
- nothing pending;
- a lone tick;
- a lone peripheral reply;
- a peripheral reply with a tick also pending.

The last of these separates the partial clear from the full clear, because the tick must still be returned by a second acknowledge.

Poll results are offered in several patterns:
- back to back, to show that the first reply is kept;
- with zero length;
- while the mask is zero.

These show acceptance rules apart from interrupt visibility, and the mask patterns (a wrong argument count, zero, then the peripheral bit) show that `irqN` tracks the mask alone. An acknowledge is timed to land exactly on a tick deadline, and the tick spacing is measured across acknowledges. Together these show that the set wins over the clear and that the period does not drift.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
  localparam int TICK_BIT = 5;
  localparam int BUS_BIT  = 4;
  localparam int AUTO_BIT = 2;
  localparam logic [7:0] MASK_AT_RESET = 8'h30;
  localparam logic [7:0] BUS_PAIR = 8'h14;

  typedef enum logic {
    OP_ACK      = 1'b0,
    OP_SET_MASK = 1'b1
  } cmd_op_e;

  typedef struct packed {
    logic ackBus;
    logic ackAll;
    logic setMask;
    logic pollTake;
    logic tick;
    logic rspGo;
  } strobe_t;
endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
  parameter int CLK_PER_MS = 100000,
  parameter int TICK_MS    = 1000
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  localparam int PERIOD = CLK_PER_MS * TICK_MS;
  localparam int CNT_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CNT_W-1:0] cnt;
  logic atDeadline;

  assign atDeadline = (cnt == CNT_W'(PERIOD - 1));

  // Counter wraps on its own, so each deadline is the previous one plus PERIOD.
  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (atDeadline) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = atDeadline;

  generate
    if (PERIOD > 1) begin : g_pulse_chk
      // R8
      tick_single_chk: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/irq_gather_ctrl.sv
module irq_gather_ctrl
  import irq_gather_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdOp,
  input  logic [7:0]       cmdArgCount,
  input  logic             pollValid,
  input  logic [LEN_W-1:0] pollLen,
  input  logic             tickIn,
  input  logic             busPending,
  output strobe_t          strb
);
  logic ackOk;

  assign ackOk = cmdValid && (cmd_op_e'(cmdOp) == OP_ACK) && (cmdArgCount == 8'd0);

  always_comb begin
    strb          = '0;
    strb.rspGo    = cmdValid;
    strb.ackBus   = ackOk && busPending;
    strb.ackAll   = ackOk && !busPending;
    strb.setMask  = cmdValid && (cmd_op_e'(cmdOp) == OP_SET_MASK) && (cmdArgCount == 8'd1);
    strb.pollTake = pollValid && !busPending && (pollLen != '0);
    strb.tick     = tickIn;
  end

  // R4 R5 R7
  cmd_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ackBus, strb.ackAll, strb.setMask}));

  // R3
  poll_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pollValid && busPending) |-> !strb.pollTake);
endmodule

// File: rtl/irq_gather_dp.sv
module irq_gather_dp
  import irq_gather_pkg::*;
#(
  parameter int REPLY_BYTES = 8,
  parameter int LEN_W = 4,
  parameter int RSP_W = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strb,
  input  logic [7:0]                   cmdArg0,
  input  logic [LEN_W-1:0]             pollLen,
  input  logic [8*REPLY_BYTES-1:0]     pollData,
  output logic                         busPending,
  output logic                         rspValid,
  output logic [RSP_W-1:0]             rspLen,
  output logic [8*(REPLY_BYTES+1)-1:0] rspData,
  output logic                         irqN
);
  localparam int RSP_BYTES = REPLY_BYTES + 1;

  logic [7:0]       pend, mask, pendNext;
  logic [7:0]       replyBuf [REPLY_BYTES];
  logic [LEN_W-1:0] replyLen, lenTake;
  logic [RSP_W-1:0] rspLenNext;
  logic [8*RSP_BYTES-1:0] rspDataNext;

  assign busPending = pend[BUS_BIT];
  assign lenTake = (pollLen > LEN_W'(REPLY_BYTES)) ? LEN_W'(REPLY_BYTES) : pollLen;

  always_comb begin
    pendNext = pend;
    if (strb.ackAll) pendNext = '0;
    if (strb.ackBus) begin
      pendNext[BUS_BIT]  = 1'b0;
      pendNext[AUTO_BIT] = 1'b0;
    end
    // events applied last: they win over a clear in the same cycle
    if (strb.tick) pendNext[TICK_BIT] = 1'b1;
    if (strb.pollTake) begin
      pendNext[BUS_BIT]  = 1'b1;
      pendNext[AUTO_BIT] = 1'b1;
    end
  end

  always_comb begin
    rspLenNext  = '0;
    rspDataNext = '0;
    if (strb.ackBus) begin
      rspLenNext = RSP_W'(replyLen) + RSP_W'(1);
      rspDataNext[7:0] = pend & BUS_PAIR;
      for (int i = 0; i < REPLY_BYTES; i++) begin
        if (LEN_W'(i) < replyLen) rspDataNext[8*(i+1) +: 8] = replyBuf[i];
      end
    end else if (strb.ackAll) begin
      rspLenNext = RSP_W'(1);
      rspDataNext[7:0] = pend;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend     <= '0;
      mask     <= MASK_AT_RESET;
      replyLen <= '0;
      rspValid <= 1'b0;
      rspLen   <= '0;
      rspData  <= '0;
    end else begin
      pend     <= pendNext;
      rspValid <= strb.rspGo;
      rspLen   <= rspLenNext;
      rspData  <= rspDataNext;
      if (strb.setMask) mask <= cmdArg0;
      if (strb.pollTake) replyLen <= lenTake;
      else if (strb.ackBus) replyLen <= '0;
    end
  end

  generate
    for (genvar g = 0; g < REPLY_BYTES; g++) begin : g_buf
      always_ff @(posedge clk) begin
        if (!rstN) replyBuf[g] <= '0;
        else if (strb.pollTake) replyBuf[g] <= pollData[8*g +: 8];
      end
    end
  endgenerate

  assign irqN = ~|(pend & mask);

  // R1
  mask_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setMask && cmdArg0 == 8'h00) |=> irqN);

  // R4
  bus_ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackBus |=> (!pend[BUS_BIT] && !pend[AUTO_BIT]));

  // R9
  tick_survives_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick |=> pend[TICK_BIT]);

  // R3
  auto_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pend[AUTO_BIT]) |-> $past(strb.pollTake));

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rspGo |=> rspValid);
endmodule

// File: rtl/irq_gather.sv
module irq_gather
  import irq_gather_pkg::*;
#(
  parameter int CLK_PER_MS  = 100000,
  parameter int TICK_MS     = 1000,
  parameter int REPLY_BYTES = 8,
  parameter int LEN_W       = $clog2(REPLY_BYTES + 1),
  parameter int RSP_W       = $clog2(REPLY_BYTES + 2)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cmdValid,
  input  logic                         cmdOp,
  input  logic [7:0]                   cmdArgCount,
  input  logic [7:0]                   cmdArg0,
  input  logic                         pollValid,
  input  logic [LEN_W-1:0]             pollLen,
  input  logic [8*REPLY_BYTES-1:0]     pollData,
  output logic                         rspValid,
  output logic [RSP_W-1:0]             rspLen,
  output logic [8*(REPLY_BYTES+1)-1:0] rspData,
  output logic                         irqN
);
  strobe_t strb;
  logic    tickPulse;
  logic    busPending;

  irq_tick_gen #(.CLK_PER_MS(CLK_PER_MS), .TICK_MS(TICK_MS)) u_tick (
    .clk(clk), .rstN(rstN), .tick(tickPulse)
  );

  irq_gather_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdArgCount(cmdArgCount), .pollValid(pollValid), .pollLen(pollLen),
    .tickIn(tickPulse), .busPending(busPending), .strb(strb)
  );

  irq_gather_dp #(.REPLY_BYTES(REPLY_BYTES), .LEN_W(LEN_W), .RSP_W(RSP_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdArg0(cmdArg0),
    .pollLen(pollLen), .pollData(pollData), .busPending(busPending),
    .rspValid(rspValid), .rspLen(rspLen), .rspData(rspData), .irqN(irqN)
  );
endmodule

// File: tb/irq_gather_bench.sv
module irq_gather_bench;
  localparam int CPM = 3;
  localparam int TMS = 1000;
  localparam int P   = CPM * TMS;
  localparam int RB  = 8;
  localparam int LW  = $clog2(RB + 1);
  localparam int RW  = $clog2(RB + 2);

  logic clk = 0, rstN = 0;
  logic cmdValid = 0, cmdOp = 0, pollValid = 0, rspValid, irqN;
  logic [7:0] cmdArgCount = 0, cmdArg0 = 0;
  logic [LW-1:0] pollLen = 0;
  logic [8*RB-1:0] pollData = 0;
  logic [RW-1:0] rspLen;
  logic [8*(RB+1)-1:0] rspData;

  int total = 0, bad = 0, cyc = 0, lastTick = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_gather #(.CLK_PER_MS(CPM), .TICK_MS(TMS), .REPLY_BYTES(RB)) u_irq_gather (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdArgCount(cmdArgCount), .cmdArg0(cmdArg0), .pollValid(pollValid),
    .pollLen(pollLen), .pollData(pollData), .rspValid(rspValid),
    .rspLen(rspLen), .rspData(rspData), .irqN(irqN)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // caller is at a negedge; returns at the next negedge with the response
  task automatic doCmd(input logic op, input int cnt, input int arg);
    cmdValid = 1; cmdOp = op; cmdArgCount = 8'(cnt); cmdArg0 = 8'(arg);
    @(negedge clk);
    cmdValid = 0;
    check("R10 rspValid", int'(rspValid), 1);
  endtask

  task automatic doPoll(input int len, input logic [8*RB-1:0] data);
    pollValid = 1; pollLen = LW'(len); pollData = data;
    @(negedge clk);
    pollValid = 0;
  endtask

  function automatic int rb(input int i);
    return int'(rspData[8*i +: 8]);
  endfunction

  task automatic waitUntil(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic syncTick();
    while (irqN) @(negedge clk);
    lastTick = cyc;
    doCmd(0, 0, 0);
    check("R5 tick ack len", int'(rspLen), 1);
    check("R5 tick ack byte", rb(0), 8'h20);
    check("R1 irq released after ack", int'(irqN), 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R2 irqN after reset", int'(irqN), 1);
    doCmd(0, 0, 0);
    check("R2 pending empty len", int'(rspLen), 1);
    check("R2 pending empty byte", rb(0), 0);
  endtask

  task automatic t_tick_period();
    int e1;
    syncTick();
    e1 = lastTick;
    syncTick();
    check("R8 tick period", lastTick - e1, P);
  endtask

  task automatic t_poll();
    syncTick();
    doPoll(3, 64'h0000_0000_00CC_BBAA);
    check("R3 poll raises irq", int'(irqN), 0);
    doCmd(0, 1, 0);
    check("R6 bad-count ack len", int'(rspLen), 0);
    check("R6 pending kept", int'(irqN), 0);
    doCmd(0, 0, 0);
    check("R4 len", int'(rspLen), 4);
    check("R4 status byte", rb(0), 8'h14);
    check("R4 byte1", rb(1), 8'hAA);
    check("R4 byte2", rb(2), 8'hBB);
    check("R4 byte3", rb(3), 8'hCC);
    check("R4 cleared", int'(irqN), 1);
    doPoll(2, 64'h0000_0000_0000_2211);
    doPoll(1, 64'h0000_0000_0000_0099);
    doCmd(0, 0, 0);
    check("R3 second poll dropped len", int'(rspLen), 3);
    check("R3 first poll kept", rb(1), 8'h11);
    doPoll(0, 64'h0000_0000_0000_0077);
    check("R3 zero-length ignored irq", int'(irqN), 1);
    doCmd(0, 0, 0);
    check("R3 zero-length ignored ack", rb(0), 0);
  endtask

  task automatic t_mask();
    syncTick();
    doCmd(1, 2, 0);
    check("R7 set-mask rsp len", int'(rspLen), 0);
    doPoll(1, 64'h0000_0000_0000_0042);
    check("R7 bad-count set-mask ignored", int'(irqN), 0);
    doCmd(0, 0, 0);
    doCmd(1, 1, 8'h00);
    doPoll(1, 64'h0000_0000_0000_0043);
    check("R1 masked poll keeps irq high", int'(irqN), 1);
    doCmd(1, 1, 8'h10);
    check("R1 irq follows mask change", int'(irqN), 0);
    doCmd(0, 0, 0);
    check("R4 masked-period payload", rb(1), 8'h43);
    doCmd(1, 1, 8'h30);
  endtask

  task automatic t_bus_and_tick();
    syncTick();
    waitUntil(lastTick + P + 1);
    check("R8 tick pending", int'(irqN), 0);
    doPoll(1, 64'h0000_0000_0000_005A);
    doCmd(0, 0, 0);
    check("R4 mixed len", int'(rspLen), 2);
    check("R4 mixed status", rb(0), 8'h14);
    check("R4 mixed payload", rb(1), 8'h5A);
    check("R4 tick left pending", int'(irqN), 0);
    doCmd(0, 0, 0);
    check("R5 tick after bus ack", rb(0), 8'h20);
    lastTick = lastTick + P;
  endtask

  task automatic t_coincide();
    waitUntil(lastTick + P - 1);
    doCmd(0, 0, 0);
    check("R9 ack before tick returns", rb(0), 0);
    check("R9 tick survives clear", int'(irqN), 0);
    doCmd(0, 0, 0);
    check("R9 tick read back", rb(0), 8'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_tick_period();
    t_poll();
    t_mask();
    t_bus_and_tick();
    t_coincide();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule